// File: doc/BRIEF.md
# Quad UART Host Bus Channel Decoder

This block is the host-facing register access front end of a four-channel UART. From the host's chip-select, address and read/write strobe inputs it produces one-cycle read and write pulses for each channel, plus the register offset. A static strap picks between two bus conventions. In the first convention each channel has its own active-low select, and several selects may be active together so that one write reaches all of them. In the second convention one active-low select is used, and two address bits pick the channel.

On the read path the block returns the selected channel's register data. There is one exception. When a channel's divisor latch is open and both divisor bytes hold zero, reading the two divisor offsets returns a device identification code and a revision code instead. A read that selects more than one channel is refused. The block also gates the external reset: it asserts its internal reset only after the input has stayed high for longer than a minimum time.

Top module: `quad_uart_bus_decode`

## Requirements
- R1: With `mode_intel`=1, `cs_n[i]`=0 selects channel i (bit 0 = A … bit 3 = D). With all `cs_n` bits high, no strobe is produced.
- R2: With `mode_intel`=1 and several `cs_n` bits low, a write pulses `ch_wr` for every selected channel in the same cycle.
- R3: A read with more than one channel selected gives `ch_rd`=0 and a one-cycle `rd_conflict` pulse. During that access `rd_data` is 0x00.
- R4: With `mode_intel`=0, `cs_n[0]` is the only select and `addr[4:3]` picks the channel (00=A, 01=B, 10=C, 11=D). `cs_n[3:1]` are ignored, and `cs_n[0]`=1 selects nothing.
- R5: With `mode_intel`=1, `addr[4:3]` have no effect on channel selection.
- R6: A falling edge of `ior_n` or `iow_n` gives exactly one strobe pulse, one cycle after the edge is sampled, even if the line stays low. `reg_ofs` equals `addr[2:0]`.
- R7: When the selected channel has `dlab` set and both its DLL and DLM bytes are 0x00, a read at offset 1 returns 0x14 and a read at offset 0 returns 0x01.
- R8: For every other single-channel read, `rd_data` is that channel's `ch_rdata` byte. This includes the divisor offsets when either divisor byte is non-zero or `dlab` is clear.
- R9: `rst_int` rises only after `rst_in` has been sampled high on RST_MIN_NS/CLK_PERIOD_NS+1 consecutive edges (5 by default). A shorter pulse has no effect.
- R10: `rst_int` stays high until the first edge that samples `rst_in` low, and drops at that edge. While `rst_int` is high, no strobes are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-side clock |
| rst_in | input | 1 | External active-high reset, unqualified |
| mode_intel | input | 1 | Strap: 1 = per-channel selects, 0 = single select plus address |
| cs_n | input | 4 | Active-low selects; only bit 0 is used when the strap is 0 |
| addr | input | 5 | Host address; [2:0] is the register offset, [4:3] is the channel when the strap is 0 |
| ior_n | input | 1 | Active-low read strobe |
| iow_n | input | 1 | Active-low write strobe |
| dlab | input | 4 | Divisor latch access bit of each channel |
| ch_rdata | input | 32 | Register read data of each channel, byte i for channel i |
| dll_val | input | 32 | Low divisor byte of each channel |
| dlm_val | input | 32 | High divisor byte of each channel |
| rst_int | output | 1 | Qualified internal reset |
| reg_ofs | output | 3 | Register offset to the channels |
| ch_rd | output | 4 | One-cycle read pulse per channel |
| ch_wr | output | 4 | One-cycle write pulse per channel |
| rd_conflict | output | 1 | One-cycle pulse on a read that selects several channels |
| rd_data | output | 8 | Read data to the host |

## Verification
The bench writes and reads with all sixteen select patterns in the first bus mode. A decoder that merged multi-channel read data would return a non-zero OR of the bytes, and one that dropped broadcast would strobe only one channel. In the second mode the bench sweeps the channel address bits together with junk on the unused selects, and in the first mode it sweeps junk on the address bits. A swapped or leaked decode would then strobe the wrong channel. The identification readback is tested with zero divisors and again with a non-zero divisor or a closed latch, which catches a zero test applied to only one byte. Reset pulses one sample short of the limit must leave `rst_int` low, and holding a read line low must not produce a second pulse.

// File: rtl/quad_uart_bus_decode.sv
module quad_uart_bus_decode #(
  parameter int          CLK_PERIOD_NS = 10,
  parameter int          RST_MIN_NS    = 40,
  parameter logic [7:0]  ID_CODE       = 8'h14,
  parameter logic [7:0]  REV_CODE      = 8'h01
) (
  input  logic        clk,
  input  logic        rst_in,
  input  logic        mode_intel,
  input  logic [3:0]  cs_n,
  input  logic [4:0]  addr,
  input  logic        ior_n,
  input  logic        iow_n,
  input  logic [3:0]  dlab,
  input  logic [31:0] ch_rdata,
  input  logic [31:0] dll_val,
  input  logic [31:0] dlm_val,
  output logic        rst_int,
  output logic [2:0]  reg_ofs,
  output logic [3:0]  ch_rd,
  output logic [3:0]  ch_wr,
  output logic        rd_conflict,
  output logic [7:0]  rd_data
);
  localparam int RST_CNT = RST_MIN_NS / CLK_PERIOD_NS + 1;
  localparam int CW      = $clog2(RST_CNT + 1);
  localparam logic [CW-1:0] LIM = CW'(RST_CNT - 1);

  logic [CW-1:0] hi_cnt;
  logic [3:0]    sel;
  logic          multi, ior_q, iow_q, rd_edge, wr_edge;

  always_ff @(posedge clk) begin
    if (!rst_in)          hi_cnt <= '0;
    else if (hi_cnt != LIM) hi_cnt <= hi_cnt + 1'b1;
    rst_int <= rst_in && (hi_cnt == LIM);
  end

  assign sel     = mode_intel ? ~cs_n : (cs_n[0] ? 4'b0000 : (4'b0001 << addr[4:3]));
  assign multi   = (sel & (sel - 4'd1)) != 4'b0000;
  assign reg_ofs = addr[2:0];
  assign rd_edge = ior_q & ~ior_n;
  assign wr_edge = iow_q & ~iow_n;

  always_comb begin
    rd_data = 8'h00;
    if (!multi)
      for (int i = 0; i < 4; i++)
        if (sel[i]) begin
          if (dlab[i] && dll_val[8*i +: 8] == 8'h00 && dlm_val[8*i +: 8] == 8'h00 && addr[2:1] == 2'b00)
            rd_data = addr[0] ? ID_CODE : REV_CODE;
          else
            rd_data = ch_rdata[8*i +: 8];
        end
  end

  always_ff @(posedge clk) begin
    if (rst_int) begin
      ior_q       <= 1'b1;
      iow_q       <= 1'b1;
      ch_rd       <= '0;
      ch_wr       <= '0;
      rd_conflict <= 1'b0;
    end else begin
      ior_q       <= ior_n;
      iow_q       <= iow_n;
      ch_rd       <= (rd_edge && !multi) ? sel : 4'b0000;
      ch_wr       <= wr_edge ? sel : 4'b0000;
      rd_conflict <= rd_edge && multi;
    end
  end
endmodule

module quad_uart_bus_decode_chk #(
  parameter int CLK_PERIOD_NS = 10,
  parameter int RST_MIN_NS    = 40
) (
  input logic       clk,
  input logic       rst_in,
  input logic       rst_int,
  input logic       mode_intel,
  input logic [3:0] ch_rd,
  input logic [3:0] ch_wr,
  input logic       rd_conflict
);
  localparam int RST_CNT = RST_MIN_NS / CLK_PERIOD_NS + 1;
  localparam int CW      = $clog2(RST_CNT + 1);
  logic [CW-1:0] run = '0;

  always_ff @(posedge clk)
    if (!rst_in) run <= '0;
    else if (run != CW'(RST_CNT)) run <= run + 1'b1;

  assert_rst_qualified_R9: assert property (@(posedge clk) rst_int |-> run >= CW'(RST_CNT));
  assert_rst_release_R10:  assert property (@(posedge clk) !rst_in |=> !rst_int);
  assert_quiet_in_rst_R10: assert property (@(posedge clk) rst_int |=> (ch_rd == 4'b0 && ch_wr == 4'b0 && !rd_conflict));
  assert_rd_onehot_R3:     assert property (@(posedge clk) disable iff (rst_int) $onehot0(ch_rd));
  assert_conflict_quiet_R3: assert property (@(posedge clk) disable iff (rst_int) rd_conflict |-> ch_rd == 4'b0);
  assert_rd_pulse_R6:      assert property (@(posedge clk) disable iff (rst_int) (ch_rd != 4'b0) |=> ch_rd == 4'b0);
  assert_wr_pulse_R6:      assert property (@(posedge clk) disable iff (rst_int) (ch_wr != 4'b0) |=> ch_wr == 4'b0);
  assert_moto_single_R4:   assert property (@(posedge clk) disable iff (rst_int) (!mode_intel && ch_wr != 4'b0) |-> $onehot(ch_wr));
endmodule

bind quad_uart_bus_decode quad_uart_bus_decode_chk #(
  .CLK_PERIOD_NS(CLK_PERIOD_NS), .RST_MIN_NS(RST_MIN_NS)
) u_chk (.*);

// File: tb/tb_quad_uart_bus_decode.sv
module tb_quad_uart_bus_decode;
  logic        clk = 1'b0;
  logic        rst_in = 1'b0, mode_intel = 1'b1, ior_n = 1'b1, iow_n = 1'b1;
  logic [3:0]  cs_n = 4'hF, dlab = 4'h0;
  logic [4:0]  addr = '0;
  logic [31:0] ch_rdata = 32'hD3C2B1A0, dll_val = 32'h01010101, dlm_val = 32'h0;
  logic        rst_int, rd_conflict;
  logic [2:0]  reg_ofs;
  logic [3:0]  ch_rd, ch_wr;
  logic [7:0]  rd_data;
  int checks = 0, failures = 0;
  bit done = 0;

  quad_uart_bus_decode dut (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] cs, input logic [4:0] a, input logic [3:0] exp, input string req);
    @(negedge clk); cs_n = cs; addr = a; iow_n = 1'b0;
    #1 chk(reg_ofs == a[2:0], "R6 ofs", {29'b0, reg_ofs}, {29'b0, a[2:0]});
    @(negedge clk); chk(ch_wr == exp, req, {28'b0, ch_wr}, {28'b0, exp});
    @(negedge clk); chk(ch_wr == 4'b0, "R6 wr pulse", {28'b0, ch_wr}, 0);
    iow_n = 1'b1; cs_n = 4'hF;
  endtask

  task automatic do_read(input logic [3:0] cs, input logic [4:0] a, input logic [3:0] exp,
                         input bit conf, input logic [7:0] dexp, input string req);
    @(negedge clk); cs_n = cs; addr = a; ior_n = 1'b0;
    #1 chk(rd_data == dexp, req, {24'b0, rd_data}, {24'b0, dexp});
    @(negedge clk);
    chk(ch_rd == exp, req, {28'b0, ch_rd}, {28'b0, exp});
    chk(rd_conflict == conf, req, {31'b0, rd_conflict}, {31'b0, conf});
    @(negedge clk);
    chk(ch_rd == 4'b0 && !rd_conflict, "R6 rd pulse", {27'b0, rd_conflict, ch_rd}, 0);
    ior_n = 1'b1; cs_n = 4'hF;
  endtask

  task automatic t_reset;
    @(negedge clk); @(negedge clk);
    rst_in = 1'b1;
    for (int k = 0; k < 4; k++) @(negedge clk);
    chk(rst_int == 1'b0, "R9 no reset after 4 samples", {31'b0, rst_int}, 0);
    @(negedge clk);
    chk(rst_int == 1'b1, "R9 reset after 5 samples", {31'b0, rst_int}, 1);
    iow_n = 1'b0; cs_n = 4'h0;
    @(negedge clk); @(negedge clk);
    chk(rst_int == 1'b1 && ch_wr == 4'b0, "R10 held and quiet", {27'b0, rst_int, ch_wr}, 32'h10);
    iow_n = 1'b1; cs_n = 4'hF; rst_in = 1'b0;
    @(negedge clk);
    chk(rst_int == 1'b0, "R10 release", {31'b0, rst_int}, 0);
    chk(ch_rd == 0 && ch_wr == 0 && !rd_conflict, "R10 reset state", {27'b0, rd_conflict, ch_wr}, 0);
    @(negedge clk); rst_in = 1'b1;
    for (int k = 0; k < 4; k++) @(negedge clk);
    rst_in = 1'b0;
    chk(rst_int == 1'b0, "R9 short pulse ignored", {31'b0, rst_int}, 0);
    @(negedge clk);
    chk(rst_int == 1'b0, "R9 short pulse ignored", {31'b0, rst_int}, 0);
  endtask

  task automatic t_intel;
    mode_intel = 1'b1;
    for (int c = 0; c < 16; c++) begin
      logic [3:0] s;
      int n;
      logic [7:0] d;
      s = ~4'(c);
      n = $countones(s);
      do_write(4'(c), 5'b11010, s, n > 1 ? "R2 broadcast write" : "R1 intel write");
      d = 8'h00;
      for (int i = 0; i < 4; i++) if (n == 1 && s[i]) d = ch_rdata[8*i +: 8];
      do_read(4'(c), {2'(c), 3'b011}, (n > 1) ? 4'b0 : s, n > 1, d, n > 1 ? "R3 read conflict" : "R1 R5 intel read");
    end
  endtask

  task automatic t_moto;
    mode_intel = 1'b0;
    for (int a = 0; a < 4; a++) begin
      do_write(4'b1110, {2'(a), 3'b101}, 4'(1 << a), "R4 moto write");
      do_write(4'(2*a), {2'(a), 3'b000}, 4'(1 << a), "R4 unused selects ignored");
      do_read(4'b0000, {2'(a), 3'b010}, 4'(1 << a), 1'b0, ch_rdata[8*a +: 8], "R4 moto read");
    end
    do_write(4'b0001, 5'b10000, 4'b0, "R4 deselected");
    do_read(4'b1111, 5'b01000, 4'b0, 1'b0, 8'h00, "R4 deselected read");
  endtask

  task automatic t_id;
    mode_intel = 1'b1;
    dlab = 4'b0100; dll_val[23:16] = 8'h00; dlm_val[23:16] = 8'h00;
    do_read(4'b1011, 5'b00001, 4'b0100, 1'b0, 8'h14, "R7 id code");
    do_read(4'b1011, 5'b00000, 4'b0100, 1'b0, 8'h01, "R7 revision code");
    do_read(4'b1011, 5'b00010, 4'b0100, 1'b0, 8'hC2, "R8 other offset");
    dll_val[23:16] = 8'h05;
    do_read(4'b1011, 5'b00001, 4'b0100, 1'b0, 8'hC2, "R8 nonzero dll");
    dll_val[23:16] = 8'h00; dlm_val[23:16] = 8'h80;
    do_read(4'b1011, 5'b00000, 4'b0100, 1'b0, 8'hC2, "R8 nonzero dlm");
    dlm_val[23:16] = 8'h00; dlab = 4'b0000;
    do_read(4'b1011, 5'b00001, 4'b0100, 1'b0, 8'hC2, "R8 latch closed");
  endtask

  initial begin
    t_reset;
    t_intel;
    t_moto;
    t_id;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule